// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

The block turns an asynchronous serial line into whole characters. A sampling enable pulses at sixteen times the bit rate. The receiver watches for a falling edge and confirms the start bit at its middle. It then samples every following bit at its centre and assembles the character least significant bit first. Three configuration inputs set the frame: the character length (5 to 8 bits), the parity mode (none, even or odd) and the stop length (1, 1.5 or 2 bits). These inputs are meant to be driven from a line-control register and held steady while a frame is in flight.

Each completed character is loaded into a holding register and raises a data-ready flag. Four sticky flags report trouble: a parity mismatch, a missing stop bit, a break (the whole frame held low) and an overrun (a character arrived while the previous one was still unread). Software consumes the character with a data-read strobe and clears the flags with a status-read strobe.

Top module: `uart_rx_core`

## Requirements
- R1: After a synchronous reset, rx_data is 0 and data_ready and all four error flags are 0.
- R2: A start is detected on a sampling tick that sees the line low after a tick that saw it high. The start is confirmed only if the line is still low 8 ticks later. If the line is high then, the receiver returns to idle and delivers nothing. A line that stays low never starts a second frame until it has returned high.
- R3: Data bits are sampled every 16 ticks after the start confirmation, least significant bit first. The count is set by cfg_len: 00=5, 01=6, 10=7, 11=8 bits. Unused upper bits of rx_data read 0.
- R4: With cfg_par_en=1, one parity bit follows the data. cfg_par_even=1 selects even parity and 0 selects odd parity. A mismatch between the data, the received parity bit and the selected mode sets err_parity.
- R5: err_frame is set when the first stop bit samples low.
- R6: err_break is set when start, data, parity and first stop bit all sample low. Such a character loads 0x00 and also sets err_frame.
- R7: If a character completes while data_ready is 1 and rd_data is not asserted in that cycle, err_overrun is set. The held character is kept, and the new character and its other flags are discarded.
- R8: A one-cycle rd_data pulse clears data_ready and leaves the error flags unchanged.
- R9: A one-cycle rd_status pulse clears all four error flags and leaves data_ready and rx_data unchanged.
- R10: cfg_stop_long=0 selects one stop bit. cfg_stop_long=1 selects two stop bits, or 1.5 when cfg_len=00. After the first stop sample, the line is ignored for 0, 8 or 16 ticks respectively. Back-to-back frames with the selected stop length are all received, and a low pulse that lies wholly inside the ignored window starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| tick16 | input | 1 | Sampling enable, one clock wide, 16 per bit |
| cfg_len | input | 2 | Character length code (00=5 ... 11=8) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_stop_long | input | 1 | 0 = one stop bit, 1 = two (1.5 for 5-bit characters) |
| rd_data | input | 1 | Consume the holding register |
| rd_status | input | 1 | Clear the error flags |
| rx_data | output | 8 | Received character |
| data_ready | output | 1 | Holding register holds an unread character |
| err_overrun | output | 1 | Character lost to an unread predecessor |
| err_parity | output | 1 | Parity mismatch |
| err_frame | output | 1 | First stop bit sampled low |
| err_break | output | 1 | Whole frame sampled low |

## Verification
The bench sends a low glitch shorter than half a bit. A receiver without the mid-bit confirmation would deliver a phantom character. It holds the line low well past a break frame, which catches a receiver that restarts on a level instead of an edge. It places a low pulse inside the extra stop time in two-stop mode and sends the same pulse in one-stop mode. This separates a receiver that ignores the stop length from one that masks the wrong window. Two unread characters check that overrun keeps the older byte rather than overwriting it. Separate data and status reads check that neither strobe clears the other's state.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        LEN5 = 2'b00,
        LEN6 = 2'b01,
        LEN7 = 2'b10,
        LEN8 = 2'b11
    } char_len_e;

    typedef struct packed {
        char_len_e len;
        logic      par_en;
        logic      par_even;
        logic      stop_long;
    } line_cfg_t;

    typedef struct packed {
        logic parity;
        logic frame;
        logic brk;
    } char_err_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_GUARD
    } rx_state_e;

    // Index of the last data bit for a given length code (4..7).
    function automatic logic [2:0] last_bit_idx(input char_len_e len);
        return {1'b1, len};
    endfunction

    // True when data plus received parity bit disagree with the selected mode.
    function automatic logic parity_bad(input logic [DATA_W-1:0] d,
                                        input logic pbit,
                                        input logic even);
        logic sum;
        sum = ^d ^ pbit;
        return even ? sum : ~sum;
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                line,
    input  line_cfg_t           cfg,
    output logic                done,
    output logic [DATA_W-1:0]   char_q,
    output char_err_t           err_q
);
    localparam int CW  = $clog2(OSR);
    localparam int GW  = CW + 1;
    localparam int MID = OSR / 2;
    localparam logic [CW-1:0] MID_LAST = CW'(MID - 1);
    localparam logic [CW-1:0] BIT_LAST = CW'(OSR - 1);

    rx_state_e          state;
    logic [CW-1:0]      cnt;
    logic [GW-1:0]      guard;
    logic [2:0]         bit_idx;
    logic               prev;
    logic               all_low;
    logic               par_bit;
    logic [DATA_W-1:0]  shreg;
    logic [GW-1:0]      guard_load;

    // Extra stop time after the first stop sample: none, half or one bit.
    always_comb begin
        if (!cfg.stop_long)        guard_load = '0;
        else if (cfg.len == LEN5)  guard_load = GW'(MID);
        else                       guard_load = GW'(OSR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            guard   <= '0;
            bit_idx <= '0;
            prev    <= 1'b0;
            all_low <= 1'b0;
            par_bit <= 1'b0;
            shreg   <= '0;
            done    <= 1'b0;
            char_q  <= '0;
            err_q   <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                prev <= line;
                case (state)
                    RX_IDLE: begin
                        if (prev && !line) begin
                            state <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == MID_LAST) begin
                            cnt <= '0;
                            if (!line) begin
                                state   <= RX_DATA;
                                bit_idx <= '0;
                                shreg   <= '0;
                                all_low <= 1'b1;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == BIT_LAST) begin
                            cnt            <= '0;
                            shreg[bit_idx] <= line;
                            all_low        <= all_low & ~line;
                            if (bit_idx == last_bit_idx(cfg.len))
                                state <= cfg.par_en ? RX_PAR : RX_STOP;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (cnt == BIT_LAST) begin
                            cnt     <= '0;
                            par_bit <= line;
                            all_low <= all_low & ~line;
                            state   <= RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == BIT_LAST) begin
                            cnt          <= '0;
                            done         <= 1'b1;
                            char_q       <= shreg;
                            err_q.frame  <= ~line;
                            err_q.brk    <= all_low & ~line;
                            err_q.parity <= cfg.par_en &
                                            parity_bad(shreg, par_bit, cfg.par_even);
                            guard        <= guard_load;
                            state        <= (guard_load == '0) ? RX_IDLE : RX_GUARD;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_GUARD: begin
                        guard <= guard - 1'b1;
                        if (guard == GW'(1)) state <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // R2: a start that is high at its mid-point goes back to idle with no character.
    p_false_start_r2: assert property (@(posedge clk) disable iff (rst)
        (state == RX_START && tick && cnt == MID_LAST && line)
        |=> (state == RX_IDLE && !done));

    // R3: a completed character is announced for a single cycle.
    p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: a break character carries a zero byte and a framing error.
    p_break_frame_r6: assert property (@(posedge clk) disable iff (rst)
        (done && err_q.brk) |-> (err_q.frame && char_q == '0));

    // R10: the extra stop window always ends in idle.
    p_guard_end_r10: assert property (@(posedge clk) disable iff (rst)
        (state == RX_GUARD && tick && guard == GW'(1)) |=> state == RX_IDLE);

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
    import uart_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                done_in,
    input  logic [DATA_W-1:0]   char_in,
    input  char_err_t           err_in,
    input  logic                rd_data,
    input  logic                rd_status,
    output logic [DATA_W-1:0]   rx_data,
    output logic                data_ready,
    output logic                err_overrun,
    output logic                err_parity,
    output logic                err_frame,
    output logic                err_break
);
    logic lost;
    logic accept;

    assign lost   = done_in && data_ready && !rd_data;
    assign accept = done_in && !lost;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data     <= '0;
            data_ready  <= 1'b0;
            err_overrun <= 1'b0;
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_break   <= 1'b0;
        end else begin
            if (accept) rx_data <= char_in;
            if (done_in)      data_ready <= 1'b1;
            else if (rd_data) data_ready <= 1'b0;
            err_overrun <= (err_overrun && !rd_status) || lost;
            err_parity  <= (err_parity  && !rd_status) || (accept && err_in.parity);
            err_frame   <= (err_frame   && !rd_status) || (accept && err_in.frame);
            err_break   <= (err_break   && !rd_status) || (accept && err_in.brk);
        end
    end

    // R7: an unread character survives a second arrival, which raises overrun.
    p_overrun_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (data_ready && done_in && !rd_data)
        |=> (err_overrun && data_ready && $stable(rx_data)));

    // R8: a data read with no arrival empties the holding register.
    p_read_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !done_in) |=> !data_ready);

    // R9: a status read with no arrival clears every error flag.
    p_status_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_status && !done_in)
        |=> !(err_overrun || err_parity || err_frame || err_break));

    // R6: break never stands without a framing error.
    p_break_has_frame_r6: assert property (@(posedge clk) disable iff (rst)
        err_break |-> err_frame);

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_serial,
    input  logic              tick16,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_stop_long,
    input  logic              rd_data,
    input  logic              rd_status,
    output logic [7:0]        rx_data,
    output logic              data_ready,
    output logic              err_overrun,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_break
);
    line_cfg_t          cfg;
    logic               line_s;
    logic               done;
    logic [DATA_W-1:0]  char_w;
    char_err_t          err_w;

    assign cfg.len       = char_len_e'(cfg_len);
    assign cfg.par_en    = cfg_par_en;
    assign cfg.par_even  = cfg_par_even;
    assign cfg.stop_long = cfg_stop_long;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_serial),
        .dout (line_s)
    );

    uart_rx_frame #(.OSR(OSR)) u_frame (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick16),
        .line   (line_s),
        .cfg    (cfg),
        .done   (done),
        .char_q (char_w),
        .err_q  (err_w)
    );

    uart_rx_hold u_hold (
        .clk         (clk),
        .rst         (rst),
        .done_in     (done),
        .char_in     (char_w),
        .err_in      (err_w),
        .rd_data     (rd_data),
        .rd_status   (rd_status),
        .rx_data     (rx_data),
        .data_ready  (data_ready),
        .err_overrun (err_overrun),
        .err_parity  (err_parity),
        .err_frame   (err_frame),
        .err_break   (err_break)
    );

endmodule

// File: tb/uart_rx_core_test.sv
module uart_rx_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_serial = 1'b1;
    logic       tick16 = 1'b0;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_stop_long = 1'b0;
    logic       rd_data = 1'b0;
    logic       rd_status = 1'b0;
    logic [7:0] rx_data;
    logic       data_ready;
    logic       err_overrun, err_parity, err_frame, err_break;

    int nchk = 0;
    int nerr = 0;
    int got  = 0;
    bit auto_rd = 1'b0;
    bit finished = 1'b0;
    int divcnt = 0;

    typedef struct {
        logic [7:0] d;
        logic       pe;
        logic       fe;
        logic       brk;
        string      req;
    } exp_t;
    exp_t sbq[$];

    uart_rx_core uut (
        .clk(clk), .rst(rst), .rx_serial(rx_serial), .tick16(tick16),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_stop_long(cfg_stop_long), .rd_data(rd_data), .rd_status(rd_status),
        .rx_data(rx_data), .data_ready(data_ready), .err_overrun(err_overrun),
        .err_parity(err_parity), .err_frame(err_frame), .err_break(err_break)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        divcnt <= (divcnt == TICK_DIV-1) ? 0 : divcnt + 1;
        tick16 <= (divcnt == TICK_DIV-1);
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) begin
            @(posedge clk);
            while (!tick16) @(posedge clk);
        end
    endtask

    task automatic bit_out(input logic v, input int n);
        rx_serial = v;
        wait_ticks(n);
        @(negedge clk);
    endtask

    // Start, data LSB first, optional parity, then the stop bit held for stop_ticks.
    task automatic send_body(input logic [7:0] d, input int nb,
                             input logic flip_par, input logic stop_v, input int stop_ticks);
        logic p;
        p = 1'b0;
        bit_out(1'b0, 16);
        for (int i = 0; i < nb; i++) begin
            bit_out(d[i], 16);
            p = p ^ d[i];
        end
        if (cfg_par_en) bit_out((cfg_par_even ? p : ~p) ^ flip_par, 16);
        bit_out(stop_v, stop_ticks);
    endtask

    task automatic expect_char(input logic [7:0] d, input logic pe, input logic fe,
                               input logic brk, input string req);
        exp_t e;
        e.d = d; e.pe = pe; e.fe = fe; e.brk = brk; e.req = req;
        sbq.push_back(e);
    endtask

    task automatic drain(input string req);
        int t;
        t = 0;
        while (sbq.size() != 0 && t < 4000) begin
            @(negedge clk);
            t++;
        end
        chk(req, "scoreboard drained", sbq.size(), 0);
    endtask

    // Monitor: pops expected items as characters appear, then consumes them.
    initial begin
        forever begin
            @(negedge clk);
            if (auto_rd && data_ready) begin
                got++;
                if (sbq.size() == 0) begin
                    nchk++;
                    nerr++;
                    $display("FAIL R2 unexpected character: actual=%0h expected=none", rx_data);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(e.req, "rx_data", rx_data, e.d);
                    chk(e.req, "err_parity (R4)", err_parity, e.pe);
                    chk(e.req, "err_frame (R5)", err_frame, e.fe);
                    chk(e.req, "err_break (R6)", err_break, e.brk);
                    chk(e.req, "err_overrun (R7)", err_overrun, 1'b0);
                end
                rd_data = 1'b1;
                rd_status = 1'b1;
                @(negedge clk);
                rd_data = 1'b0;
                rd_status = 1'b0;
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int g0;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1", "data_ready", data_ready, 0);
        chk("R1", "rx_data", rx_data, 0);
        chk("R1", "error flags", {err_overrun, err_parity, err_frame, err_break}, 0);
        rst = 1'b0;
        wait_ticks(20);
        @(negedge clk);
        auto_rd = 1'b1;

        // R3: 8 data bits, no parity, one stop
        cfg_len = 2'b11; cfg_par_en = 0; cfg_stop_long = 0;
        expect_char(8'hA5, 0, 0, 0, "R3");
        expect_char(8'h3C, 0, 0, 0, "R3");
        send_body(8'hA5, 8, 0, 1, 16);
        send_body(8'h3C, 8, 0, 1, 32);
        drain("R3");

        // R3 R10: 5-bit characters with 1.5 stop bits, back to back
        cfg_len = 2'b00; cfg_stop_long = 1;
        expect_char(8'h15, 0, 0, 0, "R10");
        expect_char(8'h0A, 0, 0, 0, "R10");
        send_body(8'h15, 5, 0, 1, 24);
        send_body(8'h0A, 5, 0, 1, 40);
        drain("R10");

        // R10: 8-bit characters with 2 stop bits, back to back
        cfg_len = 2'b11;
        expect_char(8'hC3, 0, 0, 0, "R10");
        expect_char(8'h81, 0, 0, 0, "R10");
        send_body(8'hC3, 8, 0, 1, 32);
        send_body(8'h81, 8, 0, 1, 40);
        drain("R10");

        // R4: 7 bits even parity (clean), 7 bits odd parity with a flipped bit
        cfg_len = 2'b10; cfg_stop_long = 0; cfg_par_en = 1; cfg_par_even = 1;
        expect_char(8'h55, 0, 0, 0, "R4");
        send_body(8'h55, 7, 0, 1, 32);
        cfg_par_even = 0;
        expect_char(8'h33, 1, 0, 0, "R4");
        send_body(8'h33, 7, 1, 1, 32);
        cfg_len = 2'b01; cfg_par_even = 1;
        expect_char(8'h2D, 0, 0, 0, "R4");
        send_body(8'h2D, 6, 0, 1, 32);
        drain("R4");

        // R5: stop bit low
        cfg_len = 2'b11; cfg_par_en = 0;
        expect_char(8'h5A, 0, 1, 0, "R5");
        send_body(8'h5A, 8, 0, 0, 16);
        bit_out(1'b1, 48);
        drain("R5");

        // R6 R2: break, line held low far past the frame
        g0 = got;
        expect_char(8'h00, 0, 1, 1, "R6");
        bit_out(1'b0, 16 * 14);
        bit_out(1'b1, 64);
        drain("R6");
        chk("R2", "one character per break", got - g0, 1);

        // R2: glitch shorter than half a bit
        g0 = got;
        bit_out(1'b0, 4);
        bit_out(1'b1, 200);
        chk("R2", "glitch ignored", got - g0, 0);
        chk("R2", "data_ready after glitch", data_ready, 0);

        // R10: pulse inside the 2-stop window is ignored
        cfg_stop_long = 1;
        g0 = got;
        expect_char(8'h6B, 0, 0, 0, "R10");
        send_body(8'h6B, 8, 0, 1, 12);
        bit_out(1'b0, 11);
        bit_out(1'b1, 200);
        drain("R10");
        chk("R10", "no start in stop window", got - g0, 1);

        // R10 R2: same pulse with one stop bit is a real start
        cfg_stop_long = 0;
        g0 = got;
        expect_char(8'h6B, 0, 0, 0, "R10");
        expect_char(8'hFF, 0, 0, 0, "R2");
        send_body(8'h6B, 8, 0, 1, 12);
        bit_out(1'b0, 11);
        bit_out(1'b1, 200);
        drain("R2");
        chk("R10", "start after one stop", got - g0, 2);

        // R7 R8 R9: overrun with manual reads
        auto_rd = 1'b0;
        @(negedge clk);
        send_body(8'h11, 8, 0, 1, 32);
        send_body(8'h22, 8, 0, 1, 32);
        chk("R7", "held data kept", rx_data, 8'h11);
        chk("R7", "err_overrun", err_overrun, 1);
        chk("R7", "data_ready", data_ready, 1);
        rd_data = 1'b1;
        @(negedge clk);
        rd_data = 1'b0;
        chk("R8", "data_ready cleared", data_ready, 0);
        chk("R8", "overrun kept", err_overrun, 1);
        rd_status = 1'b1;
        @(negedge clk);
        rd_status = 1'b0;
        chk("R9", "overrun cleared", err_overrun, 0);

        // R9: status read keeps the character
        send_body(8'h4E, 8, 0, 0, 16);
        bit_out(1'b1, 48);
        chk("R5", "framing flag", err_frame, 1);
        rd_status = 1'b1;
        @(negedge clk);
        rd_status = 1'b0;
        chk("R9", "framing cleared", err_frame, 0);
        chk("R9", "data_ready kept", data_ready, 1);
        chk("R9", "rx_data kept", rx_data, 8'h4E);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule